// File: doc/BRIEF.md
# System Clock Divider and Power-Mode Controller

This block produces the CPU clock enable and a family of peripheral clock enables for a small microcontroller subsystem. Everything runs on the fast main clock. A slow subclock arrives as a one-cycle tick `sub_tick`, already synchronised into the main clock domain. The CPU clock comes from one of two sources. It is either the main clock divided by a power of two from 1 to 16, or the subclock tick itself. The peripheral enables are the main clock divided by 1, 8 and 32, plus the subclock divided by 32.

Software sets the block through one 9-bit control word with a readback path. Three event pulses move the block between its running modes and its WAIT and stop modes: a WAIT instruction, a stop request and a wake event. Entering stop mode forces some control bits to fixed values. Whether a bit is forced or kept depends on whether the CPU was running from the main clock (high/medium speed) or from the subclock (low speed). A change of clock source or divide ratio is held back until the current CPU clock period ends, so the enable never produces a shortened period.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, `ctrl_rd` = 0x0D8, `mode` = 0, and `cpu_ce` pulses once every 8 clocks. The control word layout is: bit0 main-clock stop, bit1 subclock enable, bit2 subclock select, bits5:3 divide code, bit6 main drive, bit7 sub drive, bit8 WAIT peripheral stop.
- R2: While the main clock is the source, divide code n gives one `cpu_ce` pulse every 2^n clocks. Codes 4 to 7 all give 16.
- R3: A new divide code or source takes effect only at the next `cpu_ce` pulse. The period in progress keeps its old length.
- R4: A write that sets the subclock select is ignored unless the subclock enable is already 1. Once the subclock is active, `cpu_ce` equals `sub_tick` and `mode` = 1.
- R5: A write that sets main-clock stop is ignored when the same write leaves the main clock selected.
- R6: While the main clock runs in run mode, `pf1_ce` is 1 on every clock, `pf8_ce` is 1 once per 8 clocks and `pf32_ce` is 1 once per 32 clocks. While the subclock is enabled, `sub32_ce` pulses once per 32 subclock ticks.
- R7: While main-clock stop is 1, `pf1_ce`, `pf8_ce` and `pf32_ce` stay 0 and the CPU keeps running from the subclock.
- R8: A `wait_req` pulse sets `mode` = 2 and holds `cpu_ce` at 0. The main peripheral enables keep running if bit8 = 0 and stop if bit8 = 1. A `wake` pulse returns the block to its previous running mode.
- R9: A `stop_req` pulse taken at high/medium speed sets `mode` = 3, sets the divide code to 3 and sets bits 6 and 7. All enables stay 0 until `wake`, which returns `mode` to 0.
- R10: A `stop_req` pulse taken at low speed keeps the divide code and bit6 and sets bit7. `wake` returns `mode` to 1.
- R11: Writes to the control word are ignored while `mode` is 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | One pulse per subclock period |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 9 | Control word write value |
| wait_req | input | 1 | WAIT instruction executed |
| stop_req | input | 1 | Enter stop mode |
| wake | input | 1 | Interrupt or wake event |
| cpu_ce | output | 1 | CPU clock enable |
| pf1_ce | output | 1 | Main clock /1 enable |
| pf8_ce | output | 1 | Main clock /8 enable |
| pf32_ce | output | 1 | Main clock /32 enable |
| sub32_ce | output | 1 | Subclock /32 enable |
| ctrl_rd | output | 9 | Control word readback |
| mode | output | 2 | 0 high/medium, 1 low speed, 2 WAIT, 3 stop |

## Verification
The bench writes a new divide ratio in the middle of a CPU period. A design that applied the ratio at once would show a shortened interval straight after the write. It enters stop mode once from each running mode and reads back the control word. A design that forced the same bits in both cases would lose the divide code after a low-speed stop, or would keep a stale code after a high-speed stop. It also tries to stop the main clock while that clock is still selected, and tries to write during stop. Either attempt getting through would show up as a changed readback or as dead peripheral enables.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
    localparam int CTRL_W = 9;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_WAIT = 2'd1,
        PM_STOP = 2'd2
    } pmode_t;

    typedef struct packed {
        logic              wait_pstop;
        logic              sub_drive;
        logic              main_drive;
        logic [CODE_W-1:0] div_code;
        logic              sub_sel;
        logic              sub_en;
        logic              main_stop;
    } ctrl_t;

    localparam logic [CODE_W-1:0] DIV_RESET = 3'd3;
    localparam ctrl_t CTRL_RESET = '{wait_pstop: 1'b0, sub_drive: 1'b1,
                                     main_drive: 1'b1, div_code: DIV_RESET,
                                     sub_sel: 1'b0, sub_en: 1'b0,
                                     main_stop: 1'b0};
endpackage

// File: rtl/sysclk_regs.sv
module sysclk_regs
    import sysclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              wait_req,
    input  logic              stop_req,
    input  logic              wake,
    output ctrl_t             ctrl,
    output pmode_t            pmode
);
    typedef struct packed {
        ctrl_t  regs;
        pmode_t mode;
    } rstate_t;

    rstate_t st_d, st_q;
    ctrl_t   nw;

    always_comb begin
        st_d = st_q;
        nw   = ctrl_t'(wr_data);
        case (st_q.mode)
            PM_RUN: begin
                if (wr_en) begin
                    nw.sub_sel = nw.sub_sel & st_q.regs.sub_en;
                    nw.sub_en  = nw.sub_en | nw.sub_sel;
                    if (!nw.sub_sel) nw.main_stop = 1'b0;
                    st_d.regs = nw;
                end
                if (stop_req) begin
                    st_d.mode = PM_STOP;
                    if (!st_d.regs.sub_sel) begin
                        st_d.regs.div_code   = DIV_RESET;
                        st_d.regs.main_drive = 1'b1;
                    end
                    st_d.regs.sub_drive = 1'b1;
                end else if (wait_req) begin
                    st_d.mode = PM_WAIT;
                end
            end
            default: begin
                if (wake) st_d.mode = PM_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.regs <= CTRL_RESET;
            st_q.mode <= PM_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl  = st_q.regs;
    assign pmode = st_q.mode;

    a_r4_select_needs_sub: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.regs.sub_sel |-> st_q.regs.sub_en);
    a_r11_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != PM_RUN) |=> $stable(st_q.regs));
    a_r9_stop_forces_sub_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == PM_RUN && stop_req) |=> (st_q.mode == PM_STOP && st_q.regs.sub_drive));
    a_r10_low_speed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == PM_RUN && stop_req && !wr_en && st_q.regs.sub_sel)
        |=> ($stable(st_q.regs.div_code) && $stable(st_q.regs.main_drive)));
endmodule

// File: rtl/sysclk_cpu_gen.sv
module sysclk_cpu_gen
    import sysclk_pkg::*;
#(
    parameter int MAX_LOG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              sel_sub,
    input  logic [CODE_W-1:0] div_code,
    input  logic              sub_tick,
    output logic              cpu_ce
);
    localparam int CW = MAX_LOG;

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic              act_sub;
        logic [CODE_W-1:0] act_log;
    } cstate_t;

    cstate_t st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim = CW'((1 << st_q.act_log) - 1);
        cpu_ce = run & (st_q.act_sub ? sub_tick : (st_q.cnt == lim));
        st_d = st_q;
        if (run) begin
            if (cpu_ce) begin
                st_d.cnt     = '0;
                st_d.act_sub = sel_sub;
                st_d.act_log = (int'(div_code) > MAX_LOG) ? CODE_W'(MAX_LOG) : div_code;
            end else if (!st_q.act_sub) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt     <= '0;
            st_q.act_sub <= 1'b0;
            st_q.act_log <= DIV_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    a_r3_switch_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ce |=> ($stable(st_q.act_log) && $stable(st_q.act_sub)));
endmodule

// File: rtl/sysclk_periph_gen.sv
module sysclk_periph_gen #(
    parameter int MID_LOG  = 3,
    parameter int SLOW_LOG = 5,
    parameter int SUB_LOG  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic main_on,
    input  logic sub_on,
    input  logic sub_tick,
    output logic pf1_ce,
    output logic pf8_ce,
    output logic pf32_ce,
    output logic sub32_ce
);
    typedef struct packed {
        logic [SLOW_LOG-1:0] pcnt;
        logic [SUB_LOG-1:0]  scnt;
    } pstate_t;

    pstate_t st_d, st_q;
    logic    stick;

    always_comb begin
        stick    = sub_on & sub_tick;
        pf1_ce   = main_on;
        pf8_ce   = main_on & (&st_q.pcnt[MID_LOG-1:0]);
        pf32_ce  = main_on & (&st_q.pcnt);
        sub32_ce = stick & (&st_q.scnt);
        st_d = st_q;
        if (main_on) st_d.pcnt = st_q.pcnt + 1'b1;
        if (stick)   st_d.scnt = st_q.scnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r6_slow_within_mid: assert property (@(posedge clk) disable iff (!rst_n)
        pf32_ce |-> pf8_ce);
    a_r6_sub_counter_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !stick |=> $stable(st_q.scnt));
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
    import sysclk_pkg::*;
#(
    parameter int MAX_LOG  = 4,
    parameter int MID_LOG  = 3,
    parameter int SLOW_LOG = 5,
    parameter int SUB_LOG  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_tick,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              wait_req,
    input  logic              stop_req,
    input  logic              wake,
    output logic              cpu_ce,
    output logic              pf1_ce,
    output logic              pf8_ce,
    output logic              pf32_ce,
    output logic              sub32_ce,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic [1:0]        mode
);
    ctrl_t  ctrl;
    pmode_t pmode;
    logic   main_on, sub_on, running;

    sysclk_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wait_req(wait_req), .stop_req(stop_req), .wake(wake),
        .ctrl(ctrl), .pmode(pmode)
    );

    always_comb begin
        running = (pmode == PM_RUN);
        main_on = (pmode != PM_STOP) && !ctrl.main_stop
                  && !((pmode == PM_WAIT) && ctrl.wait_pstop);
        sub_on  = (pmode != PM_STOP) && ctrl.sub_en;
        ctrl_rd = CTRL_W'(ctrl);
        case (pmode)
            PM_STOP: mode = 2'd3;
            PM_WAIT: mode = 2'd2;
            default: mode = ctrl.sub_sel ? 2'd1 : 2'd0;
        endcase
    end

    sysclk_cpu_gen #(.MAX_LOG(MAX_LOG)) u_cpu (
        .clk(clk), .rst_n(rst_n), .run(running), .sel_sub(ctrl.sub_sel),
        .div_code(ctrl.div_code), .sub_tick(sub_tick), .cpu_ce(cpu_ce)
    );

    sysclk_periph_gen #(.MID_LOG(MID_LOG), .SLOW_LOG(SLOW_LOG), .SUB_LOG(SUB_LOG)) u_pf (
        .clk(clk), .rst_n(rst_n), .main_on(main_on), .sub_on(sub_on),
        .sub_tick(sub_tick), .pf1_ce(pf1_ce), .pf8_ce(pf8_ce),
        .pf32_ce(pf32_ce), .sub32_ce(sub32_ce)
    );

    a_r7_pf_off_main_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[0] |-> !(pf1_ce || pf8_ce || pf32_ce));
    a_r8_cpu_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |-> !cpu_ce);
    a_r9_stop_all_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> !(pf1_ce || sub32_ce || cpu_ce));
endmodule

// File: tb/sim_sysclk_ctrl.sv
`timescale 1ns/1ps
module sim_sysclk_ctrl;
    logic clk = 0, rst_n = 0, sub_tick = 0, wr_en = 0, wait_req = 0, stop_req = 0, wake = 0;
    logic [8:0] wr_data = '0;
    logic cpu_ce, pf1_ce, pf8_ce, pf32_ce, sub32_ce;
    logic [8:0] ctrl_rd;
    logic [1:0] mode;
    int checks = 0, errors = 0;
    bit done = 0;

    localparam int DIVP [0:7] = '{1, 2, 4, 8, 16, 16, 16, 16};

    always #2 clk = ~clk;

    sysclk_ctrl u0 (.*);

    initial begin
        forever begin
            repeat (4) @(negedge clk);
            sub_tick = 1;
            @(negedge clk);
            sub_tick = 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int s);
        case (s)
            0: return cpu_ce;
            1: return pf1_ce;
            2: return pf8_ce;
            3: return pf32_ce;
            default: return sub32_ce;
        endcase
    endfunction

    task automatic period(input int s, output int p);
        int k;
        p = 0;
        k = 0;
        while (k < 400) begin
            @(negedge clk);
            k++;
            if (pick(s)) break;
        end
        if (k >= 400) return;
        k = 0;
        while (k < 400) begin
            @(negedge clk);
            k++;
            if (pick(s)) begin p = k; return; end
        end
    endtask

    task automatic pulses(input int s, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pick(s)) c++;
        end
    endtask

    task automatic wr(input logic [8:0] v);
        @(negedge clk); wr_en = 1; wr_data = v;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic pulse_in(input int which);
        @(negedge clk);
        if (which == 0) wait_req = 1; else if (which == 1) stop_req = 1; else wake = 1;
        @(negedge clk);
        wait_req = 0; stop_req = 0; wake = 0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #600000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int p, c;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 ctrl_rd", ctrl_rd, 9'h0D8);
        check("R1 mode", mode, 0);
        period(0, p); check("R1 cpu period", p, 8);

        // R2 vector walk over divide codes (main source)
        for (int i = 0; i < 8; i++) begin
            wr(9'(i << 3));
            period(0, p);
            check($sformatf("R2 code %0d", i), p, DIVP[i]);
        end

        // R3 mid-period change: old period completes, then new one
        wr(9'h018);
        period(0, p);
        while (!cpu_ce) @(negedge clk);
        c = 0;
        @(negedge clk); c++;
        wr_en = 1; wr_data = 9'h000;
        @(negedge clk); c++; wr_en = 0;
        while (!cpu_ce) begin @(negedge clk); c++; end
        check("R3 old period kept", c, 8);
        period(0, p); check("R3 new period", p, 1);

        // R6 peripheral enables
        period(1, p); check("R6 pf1", p, 1);
        period(2, p); check("R6 pf8", p, 8);
        period(3, p); check("R6 pf32", p, 32);

        // R5 main stop ignored while main selected
        wr(9'h019);
        check("R5 stop bit ignored", ctrl_rd[0], 0);
        pulses(1, 10, c); check("R5 pf1 still runs", c, 10);

        // R4 select without enable ignored, then enable and select
        wr(9'h004 | 9'h018);
        check("R4 select refused", ctrl_rd[2], 0);
        wr(9'h002 | 9'h018);
        wr(9'h006 | 9'h018);
        check("R4 select taken", ctrl_rd[2], 1);
        check("R4 mode low", mode, 1);
        period(0, p); period(0, p); check("R4 cpu follows sub_tick", p, 5);
        period(4, p); check("R6 sub32", p, 160);

        // R7 main stop with subclock selected
        wr(9'h007 | 9'h018);
        check("R7 stop bit set", ctrl_rd[0], 1);
        pulses(1, 40, c); check("R7 pf1 off", c, 0);
        pulses(3, 40, c); check("R7 pf32 off", c, 0);
        period(0, p); check("R7 cpu on sub", p, 5);

        // back to main, divide 8
        wr(9'h018);
        period(0, p); period(0, p); check("R2 back to main", p, 8);

        // R8 WAIT with peripheral clocks kept
        pulse_in(0);
        check("R8 mode wait", mode, 2);
        pulses(0, 40, c); check("R8 cpu held", c, 0);
        pulses(1, 20, c); check("R8 pf1 runs", c, 20);
        pulse_in(2);
        check("R8 wake mode", mode, 0);
        period(0, p); check("R8 cpu resumes", p, 8);
        // R8 WAIT with peripheral stop bit
        wr(9'h118);
        pulse_in(0);
        pulses(1, 40, c); check("R8 pf1 stopped", c, 0);
        pulses(2, 40, c); check("R8 pf8 stopped", c, 0);
        pulse_in(2);
        pulses(1, 5, c); check("R8 pf1 restored", c, 5);

        // R9 stop from high speed
        wr(9'h000);
        check("R9 pre-stop ctrl", ctrl_rd, 9'h000);
        pulse_in(1);
        check("R9 mode stop", mode, 3);
        check("R9 forced ctrl", ctrl_rd, 9'h0D8);
        pulses(1, 40, c); check("R9 pf1 quiet", c, 0);
        pulses(0, 40, c); check("R9 cpu quiet", c, 0);
        pulse_in(2);
        check("R9 wake mode", mode, 0);

        // R10 stop from low speed, R11 write ignored in stop
        wr(9'h002);
        wr(9'h00E);
        check("R10 pre-stop ctrl", ctrl_rd, 9'h00E);
        pulse_in(1);
        check("R10 kept ctrl", ctrl_rd, 9'h08E);
        pulses(4, 200, c); check("R10 sub32 quiet", c, 0);
        wr(9'h000);
        check("R11 write ignored", ctrl_rd, 9'h08E);
        pulse_in(2);
        check("R10 wake mode", mode, 1);
        period(0, p); check("R10 cpu on sub", p, 5);

        done = 1;
        summary();
        $finish;
    end
endmodule